// File: doc/BRIEF.md
# Rotational Latency Scheduler

This block tracks the angular position of a head-per-track disk as a word index that advances once every programmable number of clock cycles. When a transfer is started, it counts the rotational distance from where the head is now to the requested word. It then raises a one-cycle strobe at the moment that word arrives under the head.

A controller issues a start together with a function code and a target word. Function code zero means "no operation" and schedules nothing. While a start is waiting, and while the transfer that follows is running, the block reports itself busy. The busy flag shares one readable status word with the live position. The transfer ends when the data path signals the end of the transfer, or when a clear-all command or a reset is applied. The data path and the track contents sit outside this block.

Top module: `rot_latency_sched`

## Requirements
- R1: The word position resets to 0. After `n` clock cycles out of reset at an effective period `P`, it equals `floor(n / P) mod 2^WORD_BITS`, so it advances by exactly one every `P` cycles and wraps from the last word back to 0.
- R2: `pos_word` holds the position in bits `[WORD_BITS-1:0]` and the busy flag in bit `STATUS_W-1` (bit 17 by default). All other bits read 0.
- R3: A start with a nonzero function code, accepted while idle, makes the block busy from the next cycle on.
- R4: After an accepted start, `first_word` is high for exactly one cycle: the first cycle after the start cycle in which the position equals `target_word`. The wait is therefore the modular word distance `(target - position) mod 2^WORD_BITS` times the period. A distance of zero that is crossed at the start edge costs one full revolution.
- R5: A start with function code 0 (no-op) is ignored. Busy stays low and no strobe follows.
- R6: A start that arrives while busy is ignored. The strobe still follows the target of the first start.
- R7: After the strobe the block stays busy until `xfer_end` is applied. It is idle one cycle later.
- R8: `clear_all` cancels a waiting or running transfer, so the block is idle the next cycle and no strobe follows. The position keeps advancing.
- R9: Synchronous active-low reset cancels any waiting or running transfer and returns the position to 0.
- R10: A period value of 0 behaves as a period of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period | input | PERIOD_W | Clock cycles per word (0 treated as 1) |
| start | input | 1 | Start request pulse |
| func | input | 2 | Function code; 0 is no-op, 1 to 3 are transfer kinds |
| target_word | input | WORD_BITS | Word index at which the transfer begins |
| clear_all | input | 1 | Cancel any waiting or running transfer |
| xfer_end | input | 1 | Data path reports end of transfer |
| pos_word | output | STATUS_W | Status word: position and busy flag |
| first_word | output | 1 | One-cycle strobe: target word under the head |

## Verification
The bench uses a 16-word track. It starts transfers to every target word and varies the idle gap before each start through a full period and beyond. This way each target is approached from every position and from every prescaler phase, including the case where the target is under the head exactly at a word boundary, which tells a correct modular distance apart from one that is off by one or that misses the wrap. The sweep is repeated at periods 1, 3 and 5 and at 0. That separates position stepping from prescaler wrap and shows whether the zero period is treated as one. Separate patterns issue a no-op start, a second start while busy, a clear-all during the wait and during the transfer, and a reset during the wait. Each shows whether the cancellation or ignore path leaves the strobe, the busy flag and the position as required.

// File: rtl/rls_pkg.sv
// Shared types for the rotational latency scheduler.
// Assumes a 2-bit function code where zero is the no-op.
package rls_pkg;

    typedef enum logic [1:0] {
        FN_IDLE   = 2'd0,
        FN_FETCH  = 2'd1,
        FN_STORE  = 2'd2,
        FN_VERIFY = 2'd3
    } xfer_fn_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } sched_state_e;

endpackage

// File: rtl/rls_position.sv
// Angular position tracker: a prescaler divides the clock by the
// programmed period, and each prescaler wrap advances the word position.
// Assumes the period may change at any time; a prescaler value at or
// above the new last phase wraps on the next edge. A period of 0 acts as 1.
module rls_position #(
    parameter int WORD_BITS = 11,
    parameter int PERIOD_W  = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PERIOD_W-1:0]  period,
    output logic [WORD_BITS-1:0] pos,
    output logic                 tick
);

    logic [PERIOD_W-1:0] pre;
    logic [PERIOD_W-1:0] last_phase;

    // Last prescaler value before a word step; zero period collapses to one.
    always_comb begin
        last_phase = (period == '0) ? '0 : period - PERIOD_W'(1);
    end

    assign tick = (pre >= last_phase);

    // Prescaler and word position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
            pos <= '0;
        end else if (tick) begin
            pre <= '0;
            pos <= pos + WORD_BITS'(1);
        end else begin
            pre <= pre + PERIOD_W'(1);
        end
    end

    // R1
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(pos)) |-> (pos == $past(pos) + WORD_BITS'(1)));

    // R1
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick)) |-> $stable(pos));

endmodule

// File: rtl/rls_scheduler.sv
// Start scheduler: on an accepted start it loads the modular word distance
// to the target and counts it down on each word step, strobing when the
// target word is reached. It stays busy until the data path ends the
// transfer. Assumes pos and tick come from the position tracker.
module rls_scheduler
    import rls_pkg::*;
#(
    parameter int WORD_BITS = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           func,
    input  logic [WORD_BITS-1:0] target_word,
    input  logic                 clear_all,
    input  logic                 xfer_end,
    input  logic [WORD_BITS-1:0] pos,
    input  logic                 tick,
    output logic                 first_word,
    output logic                 busy
);

    sched_state_e         state;
    logic [WORD_BITS-1:0] words_left;
    logic [WORD_BITS-1:0] tgt_q;
    logic                 accept;

    // A start counts only when idle, not a no-op, and not cancelled.
    always_comb begin
        accept = start && (state == ST_IDLE) &&
                 (xfer_fn_e'(func) != FN_IDLE) && !clear_all;
    end

    // Strobe and busy are decoded from registered state.
    assign first_word = (state == ST_WAIT) && (words_left == '0);
    assign busy       = (state != ST_IDLE);

    // Scheduling state machine and word-distance down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            words_left <= '0;
            tgt_q      <= '0;
        end else if (clear_all) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state      <= ST_WAIT;
                        tgt_q      <= target_word;
                        // distance counted from the position after this edge
                        words_left <= target_word - pos - WORD_BITS'(tick);
                    end
                end
                ST_WAIT: begin
                    if (words_left == '0) begin
                        state <= ST_XFER;
                    end else if (tick) begin
                        words_left <= words_left - WORD_BITS'(1);
                    end
                end
                ST_XFER: begin
                    if (xfer_end) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4
    wait_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (WORD_BITS'(pos + words_left) == tgt_q));

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_word |=> !first_word);

    // R5
    nop_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (func == 2'd0)) |=> !busy);

    // R6
    busy_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(tgt_q));

    // R7
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_XFER) && !xfer_end && !clear_all) |=> (state == ST_XFER));

    // R8
    clear_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> !busy);

endmodule

// File: rtl/rot_latency_sched.sv
// Rotational latency scheduler top: joins the position tracker and the
// start scheduler and packs position and busy into one status word.
// Assumes STATUS_W exceeds WORD_BITS so the busy bit sits above the position.
module rot_latency_sched #(
    parameter int WORD_BITS = 11,
    parameter int PERIOD_W  = 24,
    parameter int STATUS_W  = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PERIOD_W-1:0]  period,
    input  logic                 start,
    input  logic [1:0]           func,
    input  logic [WORD_BITS-1:0] target_word,
    input  logic                 clear_all,
    input  logic                 xfer_end,
    output logic [STATUS_W-1:0]  pos_word,
    output logic                 first_word
);

    localparam int BUSY_BIT = STATUS_W - 1;

    logic [WORD_BITS-1:0] pos;
    logic                 tick;
    logic                 busy;

    rls_position #(
        .WORD_BITS (WORD_BITS),
        .PERIOD_W  (PERIOD_W)
    ) i_position (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (period),
        .pos    (pos),
        .tick   (tick)
    );

    rls_scheduler #(
        .WORD_BITS (WORD_BITS)
    ) i_scheduler (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .func        (func),
        .target_word (target_word),
        .clear_all   (clear_all),
        .xfer_end    (xfer_end),
        .pos         (pos),
        .tick        (tick),
        .first_word  (first_word),
        .busy        (busy)
    );

    // Status word: position in the low field, busy flag in the top bit.
    always_comb begin
        pos_word                  = '0;
        pos_word[WORD_BITS-1:0]   = pos;
        pos_word[BUSY_BIT]        = busy;
    end

    // R8
    clear_busy_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> !pos_word[BUSY_BIT]);

    // R9
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (pos_word == '0 || rst_n));

endmodule

// File: tb/test_rot_latency_sched.sv
module test_rot_latency_sched;

    localparam int CLK_PERIOD = 10;
    localparam int WB  = 4;
    localparam int PW  = 8;
    localparam int SW  = 18;
    localparam int NW  = 1 << WB;
    localparam int WD_LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] period = 8'd3;
    logic          start = 1'b0;
    logic [1:0]    func = 2'd0;
    logic [WB-1:0] target_word = '0;
    logic          clear_all = 1'b0;
    logic          xfer_end = 1'b0;
    logic [SW-1:0] pos_word;
    logic          first_word;

    rot_latency_sched #(
        .WORD_BITS (WB),
        .PERIOD_W  (PW),
        .STATUS_W  (SW)
    ) i_rot_latency_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .period      (period),
        .start       (start),
        .func        (func),
        .target_word (target_word),
        .clear_all   (clear_all),
        .xfer_end    (xfer_end),
        .pos_word    (pos_word),
        .first_word  (first_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int ncyc = 0;
    int wd = 0;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // edges since reset release; read at negedge
    always @(posedge clk) ncyc <= rst_n ? ncyc + 1 : 0;

    function automatic int model_pos();
        int eff;
        eff = (period == 0) ? 1 : int'(period);
        return (ncyc / eff) % NW;
    endfunction

    function automatic int eff_per();
        return (period == 0) ? 1 : int'(period);
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, ncyc);
        end
    endtask

    task automatic exp_word(input string req, input bit busy);
        int e;
        e = model_pos();
        if (busy) e = e | (1 << (SW - 1));
        check(req, int'(pos_word), e);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > WD_LIMIT && !done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected below %0d", wd, WD_LIMIT);
            report();
            $finish;
        end
    end

    // R9: reset with a new period, check zeroed status
    task automatic do_reset(input int per);
        @(negedge clk);
        rst_n = 1'b0;
        period = PW'(per);
        start = 1'b0; clear_all = 1'b0; xfer_end = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 reset status", int'(pos_word), 0);
        check("R9 reset strobe", int'(first_word), 0);
        rst_n = 1'b1;
    endtask

    // Follow a waiting transfer until its strobe (R3, R4, R1, R2)
    task automatic wait_strobe(input int t);
        bit seen;
        seen = 1'b0;
        for (int k = 0; k < NW * eff_per() + 3; k++) begin
            bit es;
            exp_word("R2 R3 R1 busy word while waiting", 1'b1);
            es = (model_pos() == t);
            check("R4 strobe timing", int'(first_word), int'(es));
            if (es) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (!seen) check("R4 strobe never seen", 0, 1);
    endtask

    // One full transfer: start, wait, strobe, hold, end (R3 R4 R7)
    task automatic run_case(input int t, input int f, input int gap);
        repeat (gap) @(negedge clk);
        exp_word("R2 idle word before start", 1'b0);
        start = 1'b1; func = 2'(f); target_word = WB'(t);
        @(negedge clk);
        start = 1'b0;
        wait_strobe(t);
        @(negedge clk);
        check("R4 strobe single cycle", int'(first_word), 0);
        exp_word("R7 busy after strobe", 1'b1);
        xfer_end = 1'b1;
        @(negedge clk);
        xfer_end = 1'b0;
        exp_word("R7 idle after xfer_end", 1'b0);
    endtask

    task automatic quiet_window(input string req, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            exp_word(req, 1'b0);
            check(req, int'(first_word), 0);
        end
    endtask

    initial begin
        // R9 reset, R1 position at period 3
        do_reset(3);
        for (int k = 0; k < 2 * NW * 3 + 2; k++) begin
            @(negedge clk);
            exp_word("R1 free running position", 1'b0);
        end

        // Sweep every target over every gap (phase and position) at period 3
        for (int t = 0; t < NW; t++) begin
            for (int g = 0; g < NW; g++) begin
                run_case(t, (t % 3) + 1, g);
            end
        end

        // Other periods, including zero treated as one (R10)
        for (int pi = 0; pi < 3; pi++) begin
            int per;
            per = (pi == 0) ? 1 : (pi == 1) ? 5 : 0;
            do_reset(per);
            for (int t = 0; t < NW; t++) begin
                for (int g = 0; g < 4; g++) begin
                    run_case(t, 1, g + (t % 2));
                end
            end
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                exp_word("R10 R1 position at alternate period", 1'b0);
            end
        end

        do_reset(2);
        repeat (3) @(negedge clk);

        // R5: no-op start
        start = 1'b1; func = 2'd0; target_word = WB'((model_pos() + 2) % NW);
        @(negedge clk);
        start = 1'b0;
        exp_word("R5 no-op start stays idle", 1'b0);
        quiet_window("R5 no strobe after no-op", 2 * NW * 2);

        // R6: second start while busy ignored
        begin
            int t1, t2;
            t1 = (model_pos() + 6) % NW;
            t2 = (t1 + 5) % NW;
            start = 1'b1; func = 2'd2; target_word = WB'(t1);
            @(negedge clk);
            target_word = WB'(t2); func = 2'd3;
            @(negedge clk);
            start = 1'b0;
            exp_word("R6 still busy with first start", 1'b1);
            wait_strobe(t1);
            @(negedge clk);
            xfer_end = 1'b1;
            @(negedge clk);
            xfer_end = 1'b0;
            exp_word("R6 R7 idle after end", 1'b0);
        end

        // R8: clear during wait
        start = 1'b1; func = 2'd1; target_word = WB'((model_pos() + 9) % NW);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        exp_word("R8 waiting before clear", 1'b1);
        clear_all = 1'b1;
        @(negedge clk);
        clear_all = 1'b0;
        exp_word("R8 idle after clear, position kept", 1'b0);
        quiet_window("R8 no strobe after clear", 2 * NW * 2);

        // R8: clear during transfer
        run_case((model_pos() + 3) % NW, 2, 0);
        start = 1'b1; func = 2'd1; target_word = WB'((model_pos() + 4) % NW);
        @(negedge clk);
        start = 1'b0;
        wait_strobe(int'(target_word));
        @(negedge clk);
        exp_word("R8 transfer running", 1'b1);
        clear_all = 1'b1;
        @(negedge clk);
        clear_all = 1'b0;
        exp_word("R8 idle after clear in transfer", 1'b0);

        // R9: reset during wait
        start = 1'b1; func = 2'd3; target_word = WB'((model_pos() + 10) % NW);
        @(negedge clk);
        start = 1'b0;
        do_reset(2);
        quiet_window("R9 no strobe after reset", 2 * NW * 2);

        done = 1'b1;
        report();
        $finish;
    end

endmodule